// File: doc/BRIEF.md
# Instruction Line-Fill Buffer with Critical-Word Bypass

This block sits between an instruction-fetch unit and the read port of a system bus. When a fetch misses, it asks the bus for the whole line that holds the missed word. It then places each returned beat into a fill buffer, using the word index that travels with the beat, and keeps one valid bit for each word slot. The slave may return the words in any order. The slave may be 32 or 64 bits wide.

The requested word goes to the fetch unit in the same cycle that it lands in the buffer. While the line is still filling, later fetches to words that have already arrived are served from the buffer. After the line is complete, the buffer keeps serving hits in that line until the next miss. An outstanding fill can be aborted. If the bus has already accepted the address, the rest of the beats are absorbed quietly and the buffer is discarded.

Line size depends on the kind of fetch. Cacheable fetches always use an eight-word line. Non-cacheable fetches use four or eight words, chosen by a configuration bit.

The controller has four states:
- IDLE: serves buffer hits and detects misses.
- REQ: the request is on the bus.
- FILL: beats are arriving and are forwarded.
- DRAIN: beats are absorbed after an abort.

The transitions are:
- miss_start: IDLE to REQ, on a fetch that does not hit.
- acked: REQ to FILL, on address acknowledge.
- acked_abort: REQ to DRAIN, when acknowledge and abort arrive together.
- aborted_early: REQ to IDLE, on abort without acknowledge.
- fill_complete: FILL to IDLE, when the last needed word is written; the buffer becomes live.
- fill_abort: FILL to DRAIN, on abort; or FILL to IDLE with the buffer dead, if the last word lands in the abort cycle.
- drain_complete: DRAIN to IDLE, when the last word is absorbed.

Top module: `ifill_buffer`

## Requirements
- R1: After reset the block is in IDLE. `bus_req`, `bus_abort`, `fetch_valid` and `line_done` are all 0.
- R2: A fetch in IDLE that does not hit raises `bus_req` on the next cycle. `bus_addr` is the fetch address with the low 5 bits cleared for an eight-word line, or the low 4 bits cleared for a four-word line. `bus_prio` is the `fetch_prio` captured at the miss. Request, address and priority hold until `bus_addr_ack` or an abort.
- R3: `bus_line8` is 1 for a cacheable fetch (`fetch_noncache`=0). For a non-cacheable fetch it equals `cfg_nc_line8`.
- R4: With `bus_wide`=1, a beat writes two slots: index {wdaddr[2:1],0} takes `bus_rd_data[63:32]` and index {wdaddr[2:1],1} takes `bus_rd_data[31:0]`. An eight-word line takes 4 beats and a four-word line takes 2.
- R5: With `bus_wide`=0, a beat writes only slot `wdaddr`. The word comes from `bus_rd_data[63:32]` when wdaddr[0]=0 and from `bus_rd_data[31:0]` when wdaddr[0]=1. Lines take 8 or 4 beats.
- R6: In FILL, when a beat writes the word addressed by `fetch_addr[4:2]` of a fetch in the line being filled, `fetch_valid` is 1 in that same cycle and `fetch_data` carries the word.
- R7: In FILL, a fetch to a word of the current line that is already valid is answered in the same cycle from the buffer. A fetch to a word not yet written gets `fetch_valid`=0 until the word arrives.
- R8: `line_done` rises the cycle after the beat that sets the last needed valid bit, and only if the fill was not aborted.
- R9: While `line_done` is 1, fetches in that line are answered combinationally and no request is made. A fetch to another line starts a new request.
- R10: An abort in REQ without acknowledge drives `bus_abort`=1 in that cycle. The block returns to IDLE with `bus_req` low on the next cycle, and the buffer is dead, so a repeat fetch misses.
- R11: An abort after acknowledge leads to DRAIN. There, beats are written but never forwarded. After the last beat, `line_done` stays 0 and a fetch to that line misses and issues a fresh request.
- R12: No new request is raised while a fill or drain is in progress. `bus_req` rises only out of IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_req | input | 1 | Fetch unit requests a word, held until served |
| fetch_addr | input | ADDR_W | Byte address of the requested word |
| fetch_noncache | input | 1 | Fetch is non-cacheable |
| fetch_prio | input | 2 | Arbitration priority for a resulting request |
| fetch_abort | input | 1 | Abandon the outstanding fill (branch or interrupt) |
| cfg_nc_line8 | input | 1 | Non-cacheable fetches use eight-word lines when 1 |
| fetch_valid | output | 1 | `fetch_data` is the requested word |
| fetch_data | output | WORD_W | Returned instruction word |
| bus_req | output | 1 | Line-fill request |
| bus_addr | output | ADDR_W | Line-aligned request address |
| bus_line8 | output | 1 | Request size: 1 eight words, 0 four words |
| bus_prio | output | 2 | Request priority |
| bus_abort | output | 1 | Abort of the outstanding request |
| bus_addr_ack | input | 1 | Slave accepted the request address |
| bus_wide | input | 1 | Slave is 64 bits wide |
| bus_rd_ack | input | 1 | Read-data beat valid |
| bus_rd_wdaddr | input | IDX_W | Word index of the beat within the eight-word span |
| bus_rd_data | input | 2*WORD_W | Read-data bus |
| line_done | output | 1 | Buffer holds a complete, live line |

## Verification
The assertions make several assumptions about the slave:
- No data beats arrive before the address acknowledge.
- Each beat index stays inside the requested line.
- No index is repeated within a fill.
- A four-word line only uses indices in the quadword picked by address bit 4.

They also assume the fetch unit holds `fetch_req` and `fetch_addr` steady until it is served or it aborts.

The stimulus follows all of these rules:
- Every beat order is built from the line base and the beat count, in forward or reverse order.
- The acknowledge is given only in REQ.
- Aborts are raised only in REQ or FILL.
- All inputs change at the falling edge.

// File: rtl/ifill_pkg.sv
package ifill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_FILL  = 2'd2,
        ST_DRAIN = 2'd3
    } fill_state_e;
endpackage

// File: rtl/ifill_lane_sel.sv
// Turns one read-data beat into per-slot write enables and write words.
module ifill_lane_sel #(
    parameter int LINE_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic                                   beat_en,
    input  logic                                   wide,
    input  logic [IDX_W-1:0]                       wdaddr,
    input  logic [2*WORD_W-1:0]                    rd_data,
    output logic [LINE_WORDS-1:0]                  wr_en,
    output logic [LINE_WORDS-1:0][WORD_W-1:0]      wr_word
);
    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
        // even slots use the upper lane, odd slots the lower lane
        assign wr_en[i]   = beat_en && (wide ? (wdaddr[IDX_W-1:1] == SLOT[IDX_W-1:1])
                                             : (wdaddr == SLOT));
        assign wr_word[i] = SLOT[0] ? rd_data[WORD_W-1:0] : rd_data[2*WORD_W-1:WORD_W];
    end
endmodule

// File: rtl/ifill_word_store.sv
// Word slots with one valid bit each.
module ifill_word_store #(
    parameter int LINE_WORDS = 8,
    parameter int WORD_W     = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic [LINE_WORDS-1:0]             wr_en,
    input  logic [LINE_WORDS-1:0][WORD_W-1:0] wr_word,
    output logic [LINE_WORDS-1:0]             valid,
    output logic [LINE_WORDS-1:0][WORD_W-1:0] words
);
    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
            end else if (clear) begin
                valid[i] <= 1'b0;
            end else if (wr_en[i]) begin
                valid[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en[i]) begin
                words[i] <= wr_word[i];
            end
        end
    end
endmodule

// File: rtl/ifill_buffer.sv
module ifill_buffer #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_req,
    input  logic [ADDR_W-1:0]     fetch_addr,
    input  logic                  fetch_noncache,
    input  logic [1:0]            fetch_prio,
    input  logic                  fetch_abort,
    input  logic                  cfg_nc_line8,
    output logic                  fetch_valid,
    output logic [WORD_W-1:0]     fetch_data,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_line8,
    output logic [1:0]            bus_prio,
    output logic                  bus_abort,
    input  logic                  bus_addr_ack,
    input  logic                  bus_wide,
    input  logic                  bus_rd_ack,
    input  logic [IDX_W-1:0]      bus_rd_wdaddr,
    input  logic [2*WORD_W-1:0]   bus_rd_data,
    output logic                  line_done
);
    import ifill_pkg::*;

    localparam int BYTE_W   = $clog2(WORD_W / 8);
    localparam int LINE_LSB = BYTE_W + IDX_W;
    localparam int HALF_LSB = LINE_LSB - 1;
    localparam logic [ADDR_W-1:0] MASK_FULL = ~((ADDR_W'(1) << LINE_LSB) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] MASK_HALF = ~((ADDR_W'(1) << HALF_LSB) - ADDR_W'(1));

    fill_state_e state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic              line8_q;
    logic [1:0]        prio_q;
    logic              live_q;

    logic                              beat_en;
    logic [LINE_WORDS-1:0]             wr_en;
    logic [LINE_WORDS-1:0][WORD_W-1:0] wr_word;
    logic [LINE_WORDS-1:0]             valid;
    logic [LINE_WORDS-1:0][WORD_W-1:0] words;
    logic [LINE_WORDS-1:0]             need;
    logic                              full_next;
    logic [IDX_W-1:0]                  fidx;
    logic                              same_line;
    logic                              buf_hit;
    logic                              bypass;
    logic                              miss_start;
    logic                              new_line8;

    assign beat_en = bus_rd_ack && (state_q == ST_FILL || state_q == ST_DRAIN);

    ifill_lane_sel #(.LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_lane (
        .beat_en (beat_en),
        .wide    (bus_wide),
        .wdaddr  (bus_rd_wdaddr),
        .rd_data (bus_rd_data),
        .wr_en   (wr_en),
        .wr_word (wr_word)
    );

    ifill_word_store #(.LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (miss_start),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .valid   (valid),
        .words   (words)
    );

    // slots that belong to the current line
    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_need
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
        assign need[i] = line8_q || (SLOT[IDX_W-1] == base_q[HALF_LSB]);
    end

    assign full_next = &((valid | wr_en) | ~need);
    assign fidx      = fetch_addr[LINE_LSB-1:BYTE_W];
    assign same_line = line8_q ? (fetch_addr[ADDR_W-1:LINE_LSB] == base_q[ADDR_W-1:LINE_LSB])
                               : (fetch_addr[ADDR_W-1:HALF_LSB] == base_q[ADDR_W-1:HALF_LSB]);
    assign buf_hit   = fetch_req && same_line && valid[fidx] &&
                       ((state_q == ST_FILL && !fetch_abort) || (state_q == ST_IDLE && live_q));
    assign bypass    = fetch_req && same_line && wr_en[fidx] &&
                       state_q == ST_FILL && !fetch_abort;
    assign miss_start = (state_q == ST_IDLE) && fetch_req && !buf_hit;
    assign new_line8  = !fetch_noncache || cfg_nc_line8;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_start) state_d = ST_REQ;
            ST_REQ: begin
                if (bus_addr_ack)     state_d = fetch_abort ? ST_DRAIN : ST_FILL;
                else if (fetch_abort) state_d = ST_IDLE;
            end
            ST_FILL: begin
                if (fetch_abort)    state_d = full_next ? ST_IDLE : ST_DRAIN;
                else if (full_next) state_d = ST_IDLE;
            end
            ST_DRAIN: if (full_next) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            line8_q <= 1'b0;
            prio_q  <= 2'b00;
            live_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (miss_start) begin
                base_q  <= fetch_addr & (new_line8 ? MASK_FULL : MASK_HALF);
                line8_q <= new_line8;
                prio_q  <= fetch_prio;
                live_q  <= 1'b0;
            end else if (state_q == ST_FILL && !fetch_abort && full_next) begin
                live_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_req     = (state_q == ST_REQ);
        bus_addr    = base_q;
        bus_line8   = line8_q;
        bus_prio    = prio_q;
        bus_abort   = fetch_abort && (state_q == ST_REQ || state_q == ST_FILL);
        fetch_valid = buf_hit || bypass;
        fetch_data  = bypass ? wr_word[fidx] : words[fidx];
        line_done   = (state_q == ST_IDLE) && live_q;
    end
endmodule

// File: rtl/ifill_buffer_chk.sv
module ifill_buffer_chk (
    input logic                    clk,
    input logic                    rst_n,
    input ifill_pkg::fill_state_e  state,
    input logic                    fetch_req,
    input logic                    fetch_abort,
    input logic                    fetch_valid,
    input logic                    bus_req,
    input logic [31:0]             bus_addr,
    input logic                    bus_addr_ack,
    input logic                    line_done
);
    import ifill_pkg::*;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_addr_ack && !fetch_abort |=> bus_req && $stable(bus_addr));

    p_fwd_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> fetch_req);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !bus_req);

    p_abort_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && fetch_abort && !bus_addr_ack |=> !bus_req);

    p_drain_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DRAIN |-> !fetch_valid && !bus_req && !line_done);

    p_req_from_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(state) == ST_IDLE);
endmodule

bind ifill_buffer ifill_buffer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .fetch_req    (fetch_req),
    .fetch_abort  (fetch_abort),
    .fetch_valid  (fetch_valid),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .bus_addr_ack (bus_addr_ack),
    .line_done    (line_done)
);

// File: tb/sim_ifill_buffer.sv
module sim_ifill_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_noncache = 1'b0;
    logic [1:0]  fetch_prio = 2'b00;
    logic        fetch_abort = 1'b0;
    logic        cfg_nc_line8 = 1'b0;
    logic        fetch_valid;
    logic [31:0] fetch_data;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_line8;
    logic [1:0]  bus_prio;
    logic        bus_abort;
    logic        bus_addr_ack = 1'b0;
    logic        bus_wide = 1'b0;
    logic        bus_rd_ack = 1'b0;
    logic [2:0]  bus_rd_wdaddr = '0;
    logic [63:0] bus_rd_data = '0;
    logic        line_done;

    ifill_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_noncache(fetch_noncache),
        .fetch_prio(fetch_prio), .fetch_abort(fetch_abort), .cfg_nc_line8(cfg_nc_line8),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_line8(bus_line8), .bus_prio(bus_prio),
        .bus_abort(bus_abort), .bus_addr_ack(bus_addr_ack), .bus_wide(bus_wide),
        .bus_rd_ack(bus_rd_ack), .bus_rd_wdaddr(bus_rd_wdaddr), .bus_rd_data(bus_rd_data),
        .line_done(line_done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // entry: [11] wide [10] noncache [9] cfg8 [8:6] target word [5] reverse [4] exp line8 [3:0] exp beats
    localparam logic [11:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b0, 3'd5, 1'b0, 1'b1, 4'd4},
        {1'b0, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 4'd8},
        {1'b1, 1'b1, 1'b0, 3'd6, 1'b1, 1'b0, 4'd2},
        {1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 4'd4},
        {1'b0, 1'b1, 1'b1, 3'd7, 1'b0, 1'b1, 4'd8},
        {1'b1, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 4'd4}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wval(input logic [31:0] a);
        return (a & 32'hFFFF_FFFC) ^ 32'h3C3C_A5A5;
    endfunction

    // drives one beat for the line at 32-byte base lb
    task automatic beat(input logic wide, input logic [2:0] wd, input logic [31:0] lb);
        bus_wide      = wide;
        bus_rd_ack    = 1'b1;
        bus_rd_wdaddr = wd;
        if (wide)
            bus_rd_data = {wval(lb + 32'({wd[2:1], 1'b0, 2'b00})), wval(lb + 32'({wd[2:1], 1'b1, 2'b00}))};
        else if (wd[0])
            bus_rd_data = {32'hDEAD_BEEF, wval(lb + 32'({wd, 2'b00}))};
        else
            bus_rd_data = {wval(lb + 32'({wd, 2'b00})), 32'hDEAD_BEEF};
    endtask

    // presents a fetch and returns at the falling edge where the request is up
    task automatic issue(input logic [31:0] a, input logic nc, input logic [1:0] pr);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; fetch_noncache = nc; fetch_prio = pr;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 fetch_valid", 32'(fetch_valid), 0);
        chk("R1 line_done", 32'(line_done), 0);
        chk("R1 bus_abort", 32'(bus_abort), 0);

        // table-driven fills
        for (int n = 0; n < 6; n++) begin
            logic [11:0] e;
            logic        wide, l8;
            logic [2:0]  tw, bw, wd;
            logic [3:0]  nb;
            logic [31:0] lb, a, al, a2;
            int          b;
            bit          seen;
            e  = VEC[n];
            wide = e[11]; tw = e[8:6]; l8 = e[4]; nb = e[3:0];
            cfg_nc_line8 = e[9];
            lb = 32'h1000_0000 + 32'(n * 256);
            a  = lb + 32'({tw, 2'b00});
            al = l8 ? lb : (lb | 32'({tw[2], 4'b0000}));
            bw = l8 ? 3'd0 : {tw[2], 2'b00};
            @(negedge clk);
            fetch_req = 1'b1; fetch_addr = a; fetch_noncache = e[10]; fetch_prio = 2'(n);
            #1;
            chk("R2 miss no forward", 32'(fetch_valid), 0);
            @(negedge clk); #1;
            chk("R2 bus_req", 32'(bus_req), 1);
            chk("R2 bus_addr", bus_addr, al);
            chk("R2 bus_prio", 32'(bus_prio), 32'(n[1:0]));
            chk("R3 bus_line8", 32'(bus_line8), 32'(l8));
            bus_addr_ack = 1'b1;
            seen = 1'b0;
            for (int k = 0; k < int'(nb); k++) begin
                @(negedge clk);
                bus_addr_ack = 1'b0;
                b  = e[5] ? (int'(nb) - 1 - k) : k;
                wd = wide ? 3'(int'(bw) + 2 * b) : 3'(int'(bw) + b);
                beat(wide, wd, lb);
                #1;
                if ((wide && wd[2:1] == tw[2:1]) || (!wide && wd == tw)) begin
                    chk(wide ? "R6 R4 bypass valid" : "R6 R5 bypass valid", 32'(fetch_valid), 1);
                    chk(wide ? "R6 R4 bypass data" : "R6 R5 bypass data", fetch_data, wval(a));
                    seen = 1'b1;
                end else if (!seen) begin
                    chk("R7 wait for target", 32'(fetch_valid), 0);
                end
                if (k == int'(nb) - 1) chk("R8 not done during fill", 32'(line_done), 0);
            end
            @(negedge clk);
            bus_rd_ack = 1'b0;
            #1;
            chk("R8 line_done", 32'(line_done), 1);
            chk("R9 hit target", fetch_data, wval(a));
            a2 = al + 32'({tw[1:0] ^ 2'b01, 2'b00});
            fetch_addr = a2;
            #1;
            chk("R9 hit valid", 32'(fetch_valid), 1);
            chk(wide ? "R9 R4 hit data" : "R9 R5 hit data", fetch_data, wval(a2));
            @(negedge clk); #1;
            chk("R9 no request on hit", 32'(bus_req), 0);
            fetch_req = 1'b0;
        end

        // partial-buffer service during a fill
        begin
            logic [31:0] lb;
            lb = 32'h2000_0000;
            cfg_nc_line8 = 1'b0;
            issue(lb + 24, 1'b0, 2'd1);
            bus_addr_ack = 1'b1;
            @(negedge clk);
            bus_addr_ack = 1'b0;
            beat(1'b0, 3'd6, lb); #1;
            chk("R6 target first", fetch_data, wval(lb + 24));
            @(negedge clk);
            beat(1'b0, 3'd0, lb); fetch_addr = lb + 12; #1;
            chk("R7 missing word waits", 32'(fetch_valid), 0);
            @(negedge clk);
            beat(1'b0, 3'd3, lb); fetch_addr = lb; #1;
            chk("R7 partial hit valid", 32'(fetch_valid), 1);
            chk("R7 partial hit data", fetch_data, wval(lb));
            for (int k = 0; k < 5; k++) begin
                logic [2:0] wl [5] = '{3'd1, 3'd2, 3'd4, 3'd5, 3'd7};
                @(negedge clk);
                beat(1'b0, wl[k], lb);
            end
            @(negedge clk);
            bus_rd_ack = 1'b0; fetch_addr = lb + 20; #1;
            chk("R8 done after out-of-order fill", 32'(line_done), 1);
            chk("R9 hit after fill", fetch_data, wval(lb + 20));
            fetch_req = 1'b0;
        end

        // abort before acknowledge
        begin
            logic [31:0] lb;
            lb = 32'h3000_0000;
            issue(lb + 8, 1'b0, 2'd3);
            fetch_abort = 1'b1; #1;
            chk("R10 bus_abort", 32'(bus_abort), 1);
            @(negedge clk);
            fetch_abort = 1'b0; fetch_req = 1'b0; #1;
            chk("R10 request dropped", 32'(bus_req), 0);
            chk("R10 no line", 32'(line_done), 0);
            @(negedge clk);
            fetch_req = 1'b1; #1;
            chk("R10 repeat fetch misses", 32'(fetch_valid), 0);
            @(negedge clk); #1;
            chk("R10 new request", 32'(bus_req), 1);
            bus_addr_ack = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                bus_addr_ack = 1'b0;
                beat(1'b1, 3'(2 * k), lb);
            end
            @(negedge clk);
            bus_rd_ack = 1'b0; #1;
            chk("R10 refill data", fetch_data, wval(lb + 8));
            fetch_req = 1'b0;
        end

        // abort after acknowledge, then refetch
        begin
            logic [31:0] lb;
            lb = 32'h4000_0000;
            cfg_nc_line8 = 1'b0;
            issue(lb + 4, 1'b1, 2'd0);
            bus_addr_ack = 1'b1;
            @(negedge clk);
            bus_addr_ack = 1'b0;
            beat(1'b0, 3'd0, lb); #1;
            chk("R7 non-target beat", 32'(fetch_valid), 0);
            @(negedge clk);
            bus_rd_ack = 1'b0; fetch_abort = 1'b1; #1;
            chk("R11 bus_abort in fill", 32'(bus_abort), 1);
            @(negedge clk);
            fetch_abort = 1'b0;
            beat(1'b0, 3'd1, lb); #1;
            chk("R11 target not forwarded", 32'(fetch_valid), 0);
            @(negedge clk);
            beat(1'b0, 3'd2, lb); #1;
            chk("R12 no request while draining", 32'(bus_req), 0);
            @(negedge clk);
            beat(1'b0, 3'd3, lb); #1;
            chk("R12 no request on last drain beat", 32'(bus_req), 0);
            @(negedge clk);
            bus_rd_ack = 1'b0; #1;
            chk("R11 line discarded", 32'(line_done), 0);
            chk("R11 no hit after drain", 32'(fetch_valid), 0);
            @(negedge clk); #1;
            chk("R11 fresh request", 32'(bus_req), 1);
            chk("R11 fresh address", bus_addr, lb);
            bus_addr_ack = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                bus_addr_ack = 1'b0;
                beat(1'b0, 3'(k), lb);
            end
            @(negedge clk);
            bus_rd_ack = 1'b0; #1;
            chk("R11 refill done", 32'(line_done), 1);
            chk("R11 refill data", fetch_data, wval(lb + 4));
            fetch_req = 1'b0;
        end

        @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule